// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is an SPI master that sits behind a 32-bit register interface addressed in bytes. Software queues bytes into a 256-entry transmit FIFO. While the transfer inhibit control bit is clear, a shift engine takes bytes from that FIFO one at a time. It clocks each byte out on `sclk`/`mosi` in SPI mode 0, most significant bit first. It gathers the byte returned on `miso` and places it in a 256-entry receive FIFO. Software reads the received bytes back from the receive data register. Status, occupancy and slave-select registers let software follow progress and drive a parameterised set of active-low chip selects.

The block does not contain an interrupt controller. It drives three single-cycle event pulses (transmit FIFO drained, receive FIFO filled, receive overrun) for a separate block to collect. Writing a fixed key value to the reset register returns the whole block to its reset state.

Top module: `spi_fifo_master`

## Requirements
- R1: Registers decode on the full byte address: 0x40 reset key, 0x60 control, 0x64 status, 0x68 transmit data, 0x6C receive data, 0x70 slave select, 0x74 transmit occupancy, 0x78 receive occupancy. Status reads {tx_full[3], tx_empty[2], rx_full[1], rx_empty[0]}, so the value after reset is 0x5. Writes to status change nothing.
- R2: Writing exactly 0x0000000A to 0x40 returns the block to its reset state: FIFOs empty, control 0, slave select all ones. Any other value written there has no effect.
- R3: Control bit 5 empties the transmit FIFO and bit 6 empties the receive FIFO, in the cycle they are written. Both always read back 0. The other written bits read back as written.
- R4: While control bit 8 (inhibit) is set, no transfer starts and `sclk` stays low.
- R5: A write to transmit data pushes wdata[7:0]. A push to a full transmit FIFO (256 bytes) is dropped.
- R6: With inhibit clear, queued bytes are sent in order in SPI mode 0, MSB first, with one `sclk` period equal to CLK_DIV system clocks. `miso` is sampled on the rising edge, and each 8-bit result is pushed into the receive FIFO in order.
- R7: A byte that completes while the receive FIFO holds 256 bytes is discarded, and `ev_rx_overrun` pulses for one cycle.
- R8: Reading receive data while the receive FIFO is empty returns 0xDEADBEEF and changes no state. Otherwise the read returns the oldest byte zero-extended and pops it.
- R9: The slave-select register resets to all ones. `cs_n[i]` equals bit i of the register, so a chip select is active when its bit is 0.
- R10: Each occupancy register reads fill count minus one, or 0 when the FIFO is empty.
- R11: `ev_tx_empty` pulses once when the last queued byte leaves the transmit FIFO. `ev_rx_full` pulses once when the receive FIFO reaches 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive data) |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sclk | output | 1 | SPI serial clock, idles low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | NUM_CS | Active-low chip selects |
| ev_tx_empty | output | 1 | Pulse: transmit FIFO drained |
| ev_rx_full | output | 1 | Pulse: receive FIFO became full |
| ev_rx_overrun | output | 1 | Pulse: received byte dropped |

## Verification
Random batches of one to four bytes are transferred with random upper write bits. `miso` is looped back from `mosi`, either straight or inverted at random. Straight loopback confirms that bit order and byte order survive the round trip. Inverted loopback confirms that the received data really comes from `miso` and not from the transmit path. Directed sequences cover the edge cases: filling the transmit FIFO with 256 bytes and then overfilling it, filling the receive FIFO to trigger an overrun, reading while empty, wrong and correct reset key values, and FIFO clears issued while inhibited. These separate the full and empty boundaries from normal flow.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH   = 256,
  parameter int CLK_DIV = 4,
  parameter int NUM_CS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              ev_tx_empty,
  output logic              ev_rx_full,
  output logic              ev_rx_overrun
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  localparam logic [7:0] A_KEY  = 8'h40;
  localparam logic [7:0] A_CTRL = 8'h60;
  localparam logic [7:0] A_STAT = 8'h64;
  localparam logic [7:0] A_TXD  = 8'h68;
  localparam logic [7:0] A_RXD  = 8'h6C;
  localparam logic [7:0] A_SEL  = 8'h70;
  localparam logic [7:0] A_TXO  = 8'h74;
  localparam logic [7:0] A_RXO  = 8'h78;

  logic [7:0]        tx_mem [DEPTH];
  logic [7:0]        rx_mem [DEPTH];
  logic [AW-1:0]     tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic [31:0]       ctrl_q;
  logic [NUM_CS-1:0] sel_q;
  logic              busy, sclk_q;
  logic [DW-1:0]     div;
  logic [2:0]        bitn;
  logic [7:0]        txsh, rxsh;

  wire srst   = wr_en && addr == A_KEY && wdata == 32'h0000_000A;
  wire kill   = !rst_n || srst;
  wire ctl_wr = wr_en && addr == A_CTRL;
  wire tx_clr = ctl_wr && wdata[5];
  wire rx_clr = ctl_wr && wdata[6];

  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;
  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_full  = rx_cnt == CW'(DEPTH);

  wire tick    = busy && div == DW'(HALF - 1);
  wire done    = tick && sclk_q && bitn == 3'd7;
  wire start   = !busy && !ctrl_q[8] && !tx_empty && !tx_clr;
  wire tx_push = wr_en && addr == A_TXD && !tx_full;
  wire rx_push = done && !rx_full;
  wire rx_pop  = rd_en && addr == A_RXD && !rx_empty;

  assign ev_rx_overrun = done && rx_full && !kill;
  assign ev_tx_empty   = start && !tx_push && tx_cnt == CW'(1) && !kill;
  assign ev_rx_full    = rx_push && !rx_pop && !rx_clr && !kill && rx_cnt == CW'(DEPTH - 1);

  assign sclk = sclk_q;
  assign mosi = txsh[7];
  assign cs_n = sel_q;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rxsh;
  end

  always_ff @(posedge clk) begin
    if (kill || tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
    end
  end

  always_ff @(posedge clk) begin
    if (kill || rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      ctrl_q <= '0;
      sel_q  <= '1;
    end else begin
      if (ctl_wr) ctrl_q <= wdata & ~32'h0000_0060;
      if (wr_en && addr == A_SEL) sel_q <= wdata[NUM_CS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      busy <= 1'b0; sclk_q <= 1'b0; div <= '0; bitn <= '0;
      txsh <= '0; rxsh <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        txsh <= tx_mem[tx_rp];
        div  <= '0;
        bitn <= '0;
      end
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rxsh   <= {rxsh[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            txsh <= '0;
          end else begin
            bitn <= bitn + 1'b1;
            txsh <= {txsh[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = ctrl_q;
      A_STAT: rdata = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
      A_RXD:  rdata = rx_empty ? 32'hDEAD_BEEF : {24'd0, rx_mem[rx_rp]};
      A_SEL:  rdata = {{(32-NUM_CS){1'b0}}, sel_q};
      A_TXO:  rdata = tx_empty ? '0 : {{(32-CW){1'b0}}, tx_cnt - CW'(1)};
      A_RXO:  rdata = rx_empty ? '0 : {{(32-CW){1'b0}}, rx_cnt - CW'(1)};
      default: rdata = '0;
    endcase
  end

  a_r4_inhibit_holds: assert property (@(posedge clk) disable iff (kill)
    (ctrl_q[8] && !busy) |=> !busy);
  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (kill)
    !busy |-> !sclk);
  a_r7_overrun_keeps_full: assert property (@(posedge clk) disable iff (kill)
    (ev_rx_overrun && !rx_pop && !rx_clr) |=> rx_cnt == CW'(DEPTH));
  a_r8_empty_read_marker: assert property (@(posedge clk) disable iff (kill)
    (rd_en && addr == A_RXD && rx_cnt == '0) |-> rdata == 32'hDEAD_BEEF);
  a_r2_key_restores_select: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (&cs_n && tx_cnt == '0 && rx_cnt == '0));
  a_r3_tx_clear_empties: assert property (@(posedge clk) disable iff (kill)
    tx_clr |=> tx_cnt == '0);
  a_r5_tx_bounded: assert property (@(posedge clk) disable iff (kill)
    tx_cnt <= CW'(DEPTH));
endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  localparam int DEPTH = 256, CLK_DIV = 4, NUM_CS = 1;
  localparam int BYTE_T = 8 * CLK_DIV + 2;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, inv = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sclk, mosi, miso;
  logic [NUM_CS-1:0] cs_n;
  logic ev_tx_empty, ev_rx_full, ev_rx_overrun;

  int checks = 0, errors = 0, finished = 0;
  int n_txe = 0, n_rxf = 0, n_ovr = 0;
  int cyc = 0, last_rise = 0, mon_bits = 0, per_bad = 0;
  logic sclk_prev = 0;
  logic [7:0] mon_sh = 0;

  always #5 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_fifo_master #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV), .NUM_CS(NUM_CS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full),
    .ev_rx_overrun(ev_rx_overrun));

  always @(negedge clk) begin
    if (ev_tx_empty) n_txe++;
    if (ev_rx_full) n_rxf++;
    if (ev_rx_overrun) n_ovr++;
    if (sclk && !sclk_prev) begin
      if (mon_bits % 8 != 0 && cyc - last_rise != CLK_DIV) per_bad++;
      last_rise = cyc;
      mon_sh = {mon_sh[6:0], mosi};
      mon_bits++;
    end
    sclk_prev = sclk;
    cyc++;
  end

  function automatic logic [31:0] occ(int n);
    return (n == 0) ? 32'd0 : 32'(n - 1);
  endfunction

  function automatic logic [31:0] stat(int tx, int rx);
    return {28'd0, tx == DEPTH, tx == 0, rx == DEPTH, rx == 0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, input logic pop);
    @(negedge clk); addr = a; rd_en = pop; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0] exp_b [4];
    int e0, m0, dummy;
    dummy = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst_n = 1;

    rd(8'h64, v, 0); check("R1 reset status", v, 32'h5);
    rd(8'h70, v, 0); check("R9 reset select", v, 32'h1);
    check("R9 reset cs_n", 32'(cs_n), 32'h1);
    rd(8'h74, v, 0); check("R10 tx occ empty", v, 0);
    rd(8'h60, v, 0); check("R1 reset ctrl", v, 0);

    rd(8'h6C, v, 1); check("R8 empty read", v, 32'hDEADBEEF);
    rd(8'h78, v, 0); check("R8 rx occ after empty read", v, 0);
    rd(8'h64, v, 0); check("R8 status after empty read", v, 32'h5);

    wr(8'h60, 32'h0000_0170);
    rd(8'h60, v, 0); check("R3 self-clear bits", v, 32'h110);
    for (int i = 0; i < 5; i++) wr(8'h68, $urandom);
    rd(8'h74, v, 0); check("R10 tx occ 5", v, 4);
    m0 = mon_bits;
    repeat (100) @(negedge clk);
    check("R4 no sclk while inhibited", 32'(mon_bits), 32'(m0));
    rd(8'h78, v, 0); check("R4 no rx while inhibited", v, 0);
    wr(8'h64, 32'hF);
    rd(8'h64, v, 0); check("R1 status write ignored", v, 32'h4 & 32'h0 | stat(5, 0));
    wr(8'h60, 32'h120);
    rd(8'h74, v, 0); check("R3 tx clear occ", v, 0);
    rd(8'h64, v, 0); check("R3 tx clear status", v, 32'h5);

    for (int b = 0; b < 12; b++) begin
      int n;
      n = 1 + int'($urandom % 4);
      inv = $urandom % 2;
      wr(8'h60, 32'h100);
      for (int i = 0; i < n; i++) begin
        v = $urandom; exp_b[i] = v[7:0]; wr(8'h68, v);
      end
      rd(8'h74, v, 0); check("R10 tx occ batch", v, occ(n));
      e0 = n_txe;
      wr(8'h60, 0);
      repeat (n * BYTE_T + 10) @(negedge clk);
      check("R11 tx empty pulse", 32'(n_txe - e0), 1);
      check("R6 msb first on mosi", 32'(mon_sh), 32'(exp_b[n-1]));
      rd(8'h78, v, 0); check("R10 rx occ batch", v, occ(n));
      for (int i = 0; i < n; i++) begin
        rd(8'h6C, v, 1); check("R6 rx byte order", v, 32'(exp_b[i] ^ {8{inv}}));
      end
      rd(8'h64, v, 0); check("R1 status idle", v, stat(0, 0));
    end
    check("R6 sclk period", 32'(per_bad), 0);

    inv = 0;
    wr(8'h60, 32'h100);
    for (int i = 0; i < DEPTH; i++) wr(8'h68, 32'(i));
    rd(8'h64, v, 0); check("R5 tx full status", v, stat(DEPTH, 0));
    wr(8'h68, 32'h77);
    rd(8'h74, v, 0); check("R5 push to full dropped", v, occ(DEPTH));
    e0 = n_rxf;
    wr(8'h60, 0);
    repeat (DEPTH * BYTE_T + 20) @(negedge clk);
    check("R11 rx full pulse", 32'(n_rxf - e0), 1);
    rd(8'h64, v, 0); check("R7 rx full status", v, stat(0, DEPTH));
    rd(8'h78, v, 0); check("R10 rx occ full", v, occ(DEPTH));
    e0 = n_ovr;
    wr(8'h68, 32'hAA);
    repeat (BYTE_T + 10) @(negedge clk);
    check("R7 overrun pulse", 32'(n_ovr - e0), 1);
    rd(8'h78, v, 0); check("R7 occ unchanged", v, occ(DEPTH));
    rd(8'h6C, v, 1); check("R7 oldest byte kept", v, 0);
    wr(8'h60, 32'h40);
    rd(8'h64, v, 0); check("R3 rx clear status", v, 32'h5);
    rd(8'h6C, v, 1); check("R8 read after clear", v, 32'hDEADBEEF);

    wr(8'h70, 0);
    check("R9 cs active low", 32'(cs_n), 0);
    wr(8'h60, 32'h100);
    wr(8'h40, 32'h5);
    check("R2 wrong key cs", 32'(cs_n), 0);
    rd(8'h60, v, 0); check("R2 wrong key ctrl", v, 32'h100);
    wr(8'h68, 32'h3C);
    wr(8'h40, 32'hA);
    check("R2 key cs", 32'(cs_n), 1);
    rd(8'h60, v, 0); check("R2 key ctrl", v, 0);
    rd(8'h74, v, 0); check("R2 key tx occ", v, 0);
    rd(8'h64, v, 0); check("R2 key status", v, 32'h5);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (finished == 0) begin
      checks++; errors++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule